// File: doc/BRIEF.md
# Converter Power-Up Initialization Sequencer

This block governs the digital side of a stereo audio converter as it leaves and re-enters power-down. An active-low power-down input holds the block idle, with the downstream digital filter held in reset and both channel words forced to zero. Once that input is released, the block steps through a fixed timeline. First comes a long release delay counted in master-clock cycles. Next is a short delay counted in frame-clock edges. Last is an initialization window whose length depends on whether the converter runs as frame-clock master or slave.

Only after the whole timeline finishes does the block raise a data-valid flag. From then on, the left and right sample words pass straight through with no added latency. In master mode the block makes the frame clock itself by dividing the master clock. In slave mode it detects the edges of an external frame clock in the master-clock domain. A state code output exposes the current stage, encoded 0 power-down, 1 release delay, 2 pre-initialization wait, 3 initialization window, 4 running.

Top module: `initSeq`

## Requirements
- R1: While `pdnN` is low, `stateCode` is 0, `filtRstN` is low, `dataValid` is low and both `leftOut` and `rightOut` are zero.
- R2: A rising `pdnN` passes through a two-flop synchronizer, and `stateCode` becomes 1 at the third rising `mclk` edge after the release.
- R3: Stage 1 lasts exactly `REL_CYC` master-clock cycles (default 147456), and `filtRstN` stays low throughout it.
- R4: On leaving stage 1, `filtRstN` goes high and stage 2 begins. Stage 2 waits for `PRE_EDGES` frame-clock rising edges and then ends on the following rising edge, so it lasts between `PRE_EDGES` and `PRE_EDGES`+1 frame periods.
- R5: Stage 3 lasts exactly `INIT_MASTER` frame periods (default 4129) when `masterMode` is 1, and exactly `INIT_SLAVE` frame periods (default 4132) when `masterMode` is 0.
- R6: When `masterMode` is 1, `lrckOut` is the master clock divided by `LR_DIV` with equal high and low times, and it paces the frame-counted stages. When `masterMode` is 0, `lrckOut` stays low and the stages are paced by rising edges of `lrckIn`.
- R7: In stages 0 through 3, `leftOut` and `rightOut` are two's-complement zero, whatever is on the inputs.
- R8: In stage 4, `dataValid` is high, and `leftOut`/`rightOut` equal `leftIn`/`rightIn` in the same cycle.
- R9: A low on `pdnN` in any stage returns `stateCode` to 0 at once, without waiting for a clock edge, and applies R1. A later release restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| pdnN | input | 1 | Active-low power-down request, asynchronous |
| masterMode | input | 1 | 1: generate the frame clock; 0: take it from `lrckIn` |
| lrckIn | input | 1 | External frame clock, used in slave mode |
| leftIn | input | W | Left channel sample word from the converter core |
| rightIn | input | W | Right channel sample word from the converter core |
| lrckOut | output | 1 | Generated frame clock (low in slave mode) |
| filtRstN | output | 1 | Active-low reset to the downstream digital filter |
| dataValid | output | 1 | High once the initialization timeline has finished |
| stateCode | output | 3 | Current stage, 0 to 4 |
| leftOut | output | W | Gated left sample word |
| rightOut | output | W | Gated right sample word |

## Verification
The hardest case to reach is a power-down that lands in the middle of the initialization window. That window only opens after the full release count and the frame-aligned wait. The bench therefore builds the block with short counts and follows `stateCode` until it reads 3. It then runs a few frames, drops `pdnN` between clock edges and checks the outputs at once. The stage lengths are measured in whole master-clock cycles, in both master mode and slave mode. This shows the pre-initialization wait falling inside its frame-aligned bounds and the initialization window matching the mode-specific frame count exactly.

// File: rtl/initSeqPkg.sv
package initSeqPkg;

  typedef enum logic [2:0] {
    ST_PDN  = 3'd0,
    ST_REL  = 3'd1,
    ST_PRE  = 3'd2,
    ST_INIT = 3'd3,
    ST_RUN  = 3'd4
  } seqStateT;

  typedef struct packed {
    logic dataEn;
    logic filtRst;
  } ctrlStrobeT;

endpackage

// File: rtl/initSeqFrame.sv
module initSeqFrame #(
  parameter int LR_DIV = 256
) (
  input  logic mclk,
  input  logic rstN,
  input  logic masterMode,
  input  logic lrckIn,
  output logic lrckOut,
  output logic frameRise
);
  localparam int DW   = (LR_DIV > 2) ? $clog2(LR_DIV) : 1;
  localparam int HALF = LR_DIV / 2;

  logic [DW-1:0] divCnt;
  logic genLevel;
  logic slvMeta, slvSync;
  logic level, levelQ;

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      genLevel <= 1'b0;
    end else begin
      if (divCnt == DW'(LR_DIV - 1)) divCnt <= '0;
      else                           divCnt <= divCnt + 1'b1;
      genLevel <= ((divCnt == DW'(LR_DIV - 1)) ? 1'b0 : (divCnt + 1'b1 >= DW'(HALF)));
    end
  end

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      slvMeta <= 1'b0;
      slvSync <= 1'b0;
      levelQ  <= 1'b0;
    end else begin
      slvMeta <= lrckIn;
      slvSync <= slvMeta;
      levelQ  <= level;
    end
  end

  assign level     = masterMode ? genLevel : slvSync;
  assign frameRise = level & ~levelQ;
  assign lrckOut   = masterMode & genLevel;

  assert_frame_pulse_R6: assert property (@(posedge mclk) disable iff (!rstN)
    frameRise |=> !frameRise);

endmodule

// File: rtl/initSeqCtrl.sv
module initSeqCtrl
  import initSeqPkg::*;
#(
  parameter int REL_CYC     = 147456,
  parameter int PRE_EDGES   = 3,
  parameter int INIT_MASTER = 4129,
  parameter int INIT_SLAVE  = 4132
) (
  input  logic       mclk,
  input  logic       pdnN,
  input  logic       masterMode,
  input  logic       frameRise,
  output logic       rstN,
  output logic [2:0] stateCode,
  output ctrlStrobeT strobe
);
  localparam int RW      = $clog2(REL_CYC + 1);
  localparam int INITMAX = (INIT_MASTER > INIT_SLAVE) ? INIT_MASTER : INIT_SLAVE;
  localparam int FMAX    = (INITMAX > PRE_EDGES + 1) ? INITMAX : PRE_EDGES + 1;
  localparam int FW      = $clog2(FMAX + 1);

  logic pdnMeta;
  seqStateT state;
  logic [RW-1:0] relCnt;
  logic [FW-1:0] frmCnt;
  logic [FW-1:0] initLast;

  // reset synchronizer: asserts at once, releases after two mclk edges
  always_ff @(posedge mclk or negedge pdnN) begin
    if (!pdnN) begin
      pdnMeta <= 1'b0;
      rstN    <= 1'b0;
    end else begin
      pdnMeta <= 1'b1;
      rstN    <= pdnMeta;
    end
  end

  assign initLast = masterMode ? FW'(INIT_MASTER - 1) : FW'(INIT_SLAVE - 1);

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_PDN;
      relCnt <= '0;
      frmCnt <= '0;
    end else begin
      case (state)
        ST_PDN: begin
          state  <= ST_REL;
          relCnt <= '0;
        end
        ST_REL: begin
          if (relCnt == RW'(REL_CYC - 1)) begin
            state  <= ST_PRE;
            frmCnt <= '0;
          end else begin
            relCnt <= relCnt + 1'b1;
          end
        end
        ST_PRE: begin
          if (frameRise) begin
            if (frmCnt == FW'(PRE_EDGES)) begin
              state  <= ST_INIT;
              frmCnt <= '0;
            end else begin
              frmCnt <= frmCnt + 1'b1;
            end
          end
        end
        ST_INIT: begin
          if (frameRise) begin
            if (frmCnt == initLast) state <= ST_RUN;
            else                    frmCnt <= frmCnt + 1'b1;
          end
        end
        ST_RUN:  state <= ST_RUN;
        default: state <= ST_PDN;
      endcase
    end
  end

  assign stateCode      = state;
  assign strobe.dataEn  = (state == ST_RUN);
  assign strobe.filtRst = (state == ST_PDN) || (state == ST_REL);

  assert_release_exit_R3: assert property (@(posedge mclk) disable iff (!rstN)
    (state == ST_REL) |=> (state == ST_REL) || (state == ST_PRE));

  assert_release_len_R3: assert property (@(posedge mclk) disable iff (!rstN)
    ($past(state) == ST_REL && state == ST_PRE) |-> ($past(relCnt) == RW'(REL_CYC - 1)));

  assert_init_aligned_R4: assert property (@(posedge mclk) disable iff (!rstN)
    ($past(state) == ST_PRE && state == ST_INIT) |-> $past(frameRise));

  assert_run_after_init_R5: assert property (@(posedge mclk) disable iff (!rstN)
    $rose(state == ST_RUN) |-> ($past(state) == ST_INIT) && $past(frameRise));

  assert_run_sticky_R8: assert property (@(posedge mclk) disable iff (!rstN)
    (state == ST_RUN) |=> (state == ST_RUN));

endmodule

// File: rtl/initSeqData.sv
module initSeqData
  import initSeqPkg::*;
#(
  parameter int W = 24
) (
  input  ctrlStrobeT   strobe,
  input  logic [W-1:0] leftIn,
  input  logic [W-1:0] rightIn,
  output logic [W-1:0] leftOut,
  output logic [W-1:0] rightOut
);
  always_comb begin
    leftOut  = strobe.dataEn ? leftIn  : '0;
    rightOut = strobe.dataEn ? rightIn : '0;
  end
endmodule

// File: rtl/initSeq.sv
module initSeq
  import initSeqPkg::*;
#(
  parameter int W           = 24,
  parameter int REL_CYC     = 147456,
  parameter int PRE_EDGES   = 3,
  parameter int INIT_MASTER = 4129,
  parameter int INIT_SLAVE  = 4132,
  parameter int LR_DIV      = 256
) (
  input  logic         mclk,
  input  logic         pdnN,
  input  logic         masterMode,
  input  logic         lrckIn,
  input  logic [W-1:0] leftIn,
  input  logic [W-1:0] rightIn,
  output logic         lrckOut,
  output logic         filtRstN,
  output logic         dataValid,
  output logic [2:0]   stateCode,
  output logic [W-1:0] leftOut,
  output logic [W-1:0] rightOut
);
  logic rstN;
  logic frameRise;
  ctrlStrobeT strobe;

  initSeqCtrl #(
    .REL_CYC(REL_CYC), .PRE_EDGES(PRE_EDGES),
    .INIT_MASTER(INIT_MASTER), .INIT_SLAVE(INIT_SLAVE)
  ) uCtrl (
    .mclk(mclk), .pdnN(pdnN), .masterMode(masterMode), .frameRise(frameRise),
    .rstN(rstN), .stateCode(stateCode), .strobe(strobe)
  );

  initSeqFrame #(.LR_DIV(LR_DIV)) uFrame (
    .mclk(mclk), .rstN(rstN), .masterMode(masterMode), .lrckIn(lrckIn),
    .lrckOut(lrckOut), .frameRise(frameRise)
  );

  initSeqData #(.W(W)) uData (
    .strobe(strobe), .leftIn(leftIn), .rightIn(rightIn),
    .leftOut(leftOut), .rightOut(rightOut)
  );

  assign filtRstN  = ~strobe.filtRst;
  assign dataValid = strobe.dataEn;

  assert_zero_gate_R7: assert property (@(posedge mclk) disable iff (!rstN)
    (stateCode != 3'd4) |-> (leftOut == '0) && (rightOut == '0));

  assert_filter_free_R4: assert property (@(posedge mclk) disable iff (!rstN)
    dataValid |-> filtRstN);

endmodule

// File: tb/tb_initSeq.sv
module tb_initSeq;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;
  localparam int REL = 40;
  localparam int PRE = 3;
  localparam int INM = 6;
  localparam int INS = 9;
  localparam int DIV = 8;
  localparam int SLV_HALF = 5;

  logic mclk = 1'b0;
  logic pdnN = 1'b0;
  logic masterMode = 1'b1;
  logic lrckIn = 1'b0;
  logic [W-1:0] leftIn = 24'h123456;
  logic [W-1:0] rightIn = 24'hABCDEF;
  logic lrckOut, filtRstN, dataValid;
  logic [2:0] stateCode;
  logic [W-1:0] leftOut, rightOut;

  int checks = 0;
  int errors = 0;
  int slvCnt = 0;

  initSeq #(.W(W), .REL_CYC(REL), .PRE_EDGES(PRE), .INIT_MASTER(INM),
            .INIT_SLAVE(INS), .LR_DIV(DIV)) dut (
    .mclk(mclk), .pdnN(pdnN), .masterMode(masterMode), .lrckIn(lrckIn),
    .leftIn(leftIn), .rightIn(rightIn), .lrckOut(lrckOut), .filtRstN(filtRstN),
    .dataValid(dataValid), .stateCode(stateCode), .leftOut(leftOut), .rightOut(rightOut)
  );

  always #(CLK_PERIOD/2) mclk = ~mclk;

  always @(negedge mclk) begin
    if (slvCnt == SLV_HALF - 1) begin slvCnt <= 0; lrckIn <= ~lrckIn; end
    else slvCnt <= slvCnt + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(stateCode == 3'd0, req, stateCode, 0);
    check(filtRstN == 1'b0, req, filtRstN, 0);
    check(dataValid == 1'b0, req, dataValid, 0);
    check(leftOut == '0 && rightOut == '0, req, leftOut | rightOut, 0);
  endtask

  task automatic stageLen(input logic [2:0] code, output int n);
    n = 0;
    while (stateCode == code && n < 5000) begin
      @(negedge mclk);
      n++;
    end
  endtask

  task automatic waitState(input logic [2:0] code);
    int t = 0;
    while (stateCode != code && t < 5000) begin @(negedge mclk); t++; end
  endtask

  // R2 R3 R4 R5 R7: full power-up timeline
  task automatic powerUp(input bit master);
    int n;
    int lo, hi;
    int per;
    per = master ? DIV : 2 * SLV_HALF;
    @(negedge mclk);
    masterMode = master;
    pdnN = 1'b1;
    @(negedge mclk); @(negedge mclk);
    check(stateCode == 3'd0, "R2 still idle", stateCode, 0);
    @(negedge mclk);
    check(stateCode == 3'd1, "R2 release start", stateCode, 1);
    check(filtRstN == 1'b0, "R3 filter held", filtRstN, 0);
    stageLen(3'd1, n);
    check(n == REL, "R3 release length", n, REL);
    check(stateCode == 3'd2 && filtRstN, "R4 pre-wait with filter free", stateCode, 2);
    check(leftOut == '0, "R7 zero in pre-wait", leftOut, 0);
    stageLen(3'd2, n);
    lo = PRE * per; hi = (PRE + 1) * per;
    check(n >= lo && n <= hi, "R4 pre-wait length", n, hi);
    check(stateCode == 3'd3, "R5 init entered", stateCode, 3);
    check(leftOut == '0 && rightOut == '0, "R7 zero in init", leftOut | rightOut, 0);
    stageLen(3'd3, n);
    check(n == (master ? INM : INS) * per, master ? "R5 master init length" : "R5 slave init length",
          n, (master ? INM : INS) * per);
    check(stateCode == 3'd4 && dataValid, "R8 running", stateCode, 4);
  endtask

  task automatic passThrough();
    @(negedge mclk);
    leftIn = 24'h800001; rightIn = 24'h7FFFFE;
    #1;
    check(leftOut == leftIn, "R8 left same cycle", leftOut, leftIn);
    check(rightOut == rightIn, "R8 right same cycle", rightOut, rightIn);
  endtask

  task automatic frameGen(input bit master);
    int highs = 0;
    int rises = 0;
    logic prev;
    prev = lrckOut;
    for (int i = 0; i < 2 * DIV; i++) begin
      @(negedge mclk);
      if (lrckOut) highs++;
      if (lrckOut && !prev) rises++;
      prev = lrckOut;
    end
    if (master) begin
      check(highs == DIV, "R6 duty", highs, DIV);
      check(rises == 2, "R6 period", rises, 2);
    end else begin
      check(highs == 0, "R6 slave lrckOut low", highs, 0);
    end
  endtask

  task automatic abortNow(input string req);
    #2;
    pdnN = 1'b0;
    #1;
    checkIdle(req);
    repeat (3) @(negedge mclk);
    checkIdle(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge mclk);
    checkIdle("R1 reset state");

    powerUp(1'b1);
    passThrough();
    frameGen(1'b1);
    abortNow("R9 abort from run");

    // abort in the middle of initialization (R9)
    @(negedge mclk);
    masterMode = 1'b1;
    pdnN = 1'b1;
    waitState(3'd3);
    repeat (2 * DIV) @(negedge mclk);
    check(stateCode == 3'd3, "R9 reached init", stateCode, 3);
    abortNow("R9 abort from init");

    // abort during release, then restart in slave mode
    @(negedge mclk);
    pdnN = 1'b1;
    waitState(3'd1);
    repeat (5) @(negedge mclk);
    abortNow("R9 abort from release");
    repeat (4) @(negedge mclk);

    powerUp(1'b0);
    passThrough();
    frameGen(1'b0);
    abortNow("R1 idle after slave run");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule